// File: doc/BRIEF.md
# Compare-Latch Conditional Branch Unit

This block splits conditional control flow into two steps. A compare operation places two 32-bit register values into a pair of operand latches and changes nothing else. A later branch operation selects one of ten relations, signed or unsigned, and tests it on the latched pair. The block then gives the program counter that follows the branch: either the sequential address two bytes on, or a PC-relative target built from a 10-bit halfword displacement.

No flag bits are stored. Both raw operands stay in the latches and the relation is worked out when the branch arrives, so every signed and unsigned relation reads the same storage. A condition code above nine does not branch. The block raises an illegal-condition flag so that the surrounding core can take a bad-instruction trap at the current PC. Taken/not-taken, the next PC and the illegal flag are combinational from the branch inputs and the registered latches.

Top module: `cmp_branch_unit`

## Requirements
- R1: A clock edge with `cmp_req` high loads `cmp_a` into latch A and `cmp_b` into latch B.
- R2: Without `cmp_req` the latches keep their values for any number of cycles, branches included.
- R3: Reset (`rst_n` low, asynchronous) clears both latches to zero.
- R4: Condition codes 0 and 1 test A equal to B and A not equal to B.
- R5: Codes 2, 3, 6 and 7 compare A with B as two's-complement numbers: A<B, A>B, A>=B and A<=B.
- R6: Codes 4, 5, 8 and 9 compare A with B as unsigned numbers: A<B, A>B, A>=B and A<=B.
- R7: A taken branch gives `next_pc` = `pc` + 2 + (sign-extended `br_disp`) x 2, wrapping modulo 2^32.
- R8: A legal branch that is not taken gives `next_pc` = `pc` + 2.
- R9: With `br_req` high and a code from 10 to 15, `bad_cond` is 1, `br_taken` is 0 and `next_pc` equals `pc`.
- R10: With `br_req` low, `br_taken` and `bad_cond` are 0 and `next_pc` is `pc` + 2.
- R11: If `cmp_req` and `br_req` are both high in one cycle, the branch tests the latches as they were before that cycle and the compare still loads at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_req | input | 1 | Compare strobe; loads the latches |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| br_req | input | 1 | Branch strobe |
| br_cond | input | 4 | Relation code, 0 to 9 legal |
| br_disp | input | 10 | Signed halfword displacement |
| pc | input | 32 | Address of the branch instruction |
| br_taken | output | 1 | Branch relation holds |
| next_pc | output | 32 | Address that follows |
| bad_cond | output | 1 | Illegal relation code on a branch |

## Verification
The operand pairs are random, and many are biased to equal values, to pairs that differ only in the top bit and to the extremes 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. These pairs make signed and unsigned relations disagree, so a swapped or sign-blind relation shows up. Random runs of branches with no compare between them check that the latches hold. Directed cases cover the largest forward and backward displacements, a PC that wraps, every illegal code, and a compare issued in the same cycle as a branch, which shows whether the branch reads old or new latch values.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  localparam int COND_W = 4;

  // Relation codes; the numbering is decoded by the branch instruction
  typedef enum logic [COND_W-1:0] {
    REL_EQ   = 4'd0,
    REL_NE   = 4'd1,
    REL_SLT  = 4'd2,
    REL_SGT  = 4'd3,
    REL_ULT  = 4'd4,
    REL_UGT  = 4'd5,
    REL_SGE  = 4'd6,
    REL_SLE  = 4'd7,
    REL_UGE  = 4'd8,
    REL_ULE  = 4'd9
  } rel_e;

  localparam logic [COND_W-1:0] REL_LAST = 4'd9;

  function automatic logic rel_is_legal(input logic [COND_W-1:0] code);
    return code <= REL_LAST;
  endfunction

endpackage

// File: rtl/cbu_operand_latch.sv
module cbu_operand_latch #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic [DATA_W-1:0] out_a,
  output logic [DATA_W-1:0] out_b
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_a <= '0;
      out_b <= '0;
    end else if (load) begin
      out_a <= in_a;
      out_b <= in_b;
    end
  end

endmodule

// File: rtl/cbu_relation_eval.sv
module cbu_relation_eval
  import cbu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [COND_W-1:0] code,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              hit,
  output logic              legal
);

  // Shared primitive comparisons; every relation is built from these three
  function automatic logic less_unsigned(input logic [DATA_W-1:0] x,
                                         input logic [DATA_W-1:0] y);
    return x < y;
  endfunction

  function automatic logic less_signed(input logic [DATA_W-1:0] x,
                                       input logic [DATA_W-1:0] y);
    // Flip the sign bits so an unsigned compare orders two's-complement values
    logic [DATA_W-1:0] xs;
    logic [DATA_W-1:0] ys;
    xs = {~x[DATA_W-1], x[DATA_W-2:0]};
    ys = {~y[DATA_W-1], y[DATA_W-2:0]};
    return xs < ys;
  endfunction

  logic is_eq;
  logic lt_u;
  logic gt_u;
  logic lt_s;
  logic gt_s;

  assign is_eq = (opa == opb);
  assign lt_u  = less_unsigned(opa, opb);
  assign gt_u  = less_unsigned(opb, opa);
  assign lt_s  = less_signed(opa, opb);
  assign gt_s  = less_signed(opb, opa);

  always_comb begin
    unique case (code)
      REL_EQ:  hit = is_eq;
      REL_NE:  hit = !is_eq;
      REL_SLT: hit = lt_s;
      REL_SGT: hit = gt_s;
      REL_ULT: hit = lt_u;
      REL_UGT: hit = gt_u;
      REL_SGE: hit = !lt_s;
      REL_SLE: hit = !gt_s;
      REL_UGE: hit = !lt_u;
      REL_ULE: hit = !gt_u;
      default: hit = 1'b0;
    endcase
  end

  assign legal = rel_is_legal(code);

endmodule

// File: rtl/cbu_target_gen.sv
module cbu_target_gen #(
  parameter int PC_W   = 32,
  parameter int DISP_W = 10
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  output logic [PC_W-1:0]   seq_pc,
  output logic [PC_W-1:0]   jump_pc
);

  localparam int INSN_BYTES = 2;
  localparam int PAD_W      = PC_W - DISP_W - 1;

  // Halfword displacement, sign-extended and scaled to bytes
  function automatic logic [PC_W-1:0] byte_offset(input logic [DISP_W-1:0] d);
    return {{PAD_W{d[DISP_W-1]}}, d, 1'b0};
  endfunction

  assign seq_pc  = pc + PC_W'(INSN_BYTES);
  assign jump_pc = seq_pc + byte_offset(disp);

endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cbu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter int DISP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_req,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic              br_req,
  input  logic [COND_W-1:0] br_cond,
  input  logic [DISP_W-1:0] br_disp,
  input  logic [PC_W-1:0]   pc,
  output logic              br_taken,
  output logic [PC_W-1:0]   next_pc,
  output logic              bad_cond
);

  logic [DATA_W-1:0] lat_a_q;
  logic [DATA_W-1:0] lat_b_q;
  logic              rel_hit;
  logic              rel_legal;
  logic [PC_W-1:0]   seq_pc;
  logic [PC_W-1:0]   jump_pc;

  // Named events for the checker
  logic              ev_latch_load;
  logic              ev_branch_ok;

  assign ev_latch_load = cmp_req;

  cbu_operand_latch #(.DATA_W(DATA_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ev_latch_load),
    .in_a  (cmp_a),
    .in_b  (cmp_b),
    .out_a (lat_a_q),
    .out_b (lat_b_q)
  );

  cbu_relation_eval #(.DATA_W(DATA_W)) u_rel (
    .code  (br_cond),
    .opa   (lat_a_q),
    .opb   (lat_b_q),
    .hit   (rel_hit),
    .legal (rel_legal)
  );

  cbu_target_gen #(.PC_W(PC_W), .DISP_W(DISP_W)) u_tgt (
    .pc      (pc),
    .disp    (br_disp),
    .seq_pc  (seq_pc),
    .jump_pc (jump_pc)
  );

  assign ev_branch_ok = br_req && rel_legal;
  assign br_taken     = ev_branch_ok && rel_hit;
  assign bad_cond     = br_req && !rel_legal;

  always_comb begin
    if (bad_cond)      next_pc = pc;
    else if (br_taken) next_pc = jump_pc;
    else               next_pc = seq_pc;
  end

endmodule

// File: rtl/cbu_checker.sv
module cbu_checker #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_req,
  input logic [DATA_W-1:0] cmp_a,
  input logic [DATA_W-1:0] cmp_b,
  input logic              br_req,
  input logic [PC_W-1:0]   pc,
  input logic              br_taken,
  input logic [PC_W-1:0]   next_pc,
  input logic              bad_cond,
  input logic [DATA_W-1:0] lat_a_q,
  input logic [DATA_W-1:0] lat_b_q
);

  // R1
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req |=> (lat_a_q == $past(cmp_a)) && (lat_b_q == $past(cmp_b)));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_req |=> $stable(lat_a_q) && $stable(lat_b_q));

  // R9
  bad_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cond |-> !br_taken && (next_pc == pc));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !br_req |-> !br_taken && !bad_cond && (next_pc == pc + PC_W'(2)));

  // R8
  fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req && !br_taken && !bad_cond) |-> (next_pc == pc + PC_W'(2)));

endmodule

bind cmp_branch_unit cbu_checker #(.DATA_W(DATA_W), .PC_W(PC_W)) u_cbu_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmp_req  (cmp_req),
  .cmp_a    (cmp_a),
  .cmp_b    (cmp_b),
  .br_req   (br_req),
  .pc       (pc),
  .br_taken (br_taken),
  .next_pc  (next_pc),
  .bad_cond (bad_cond),
  .lat_a_q  (lat_a_q),
  .lat_b_q  (lat_b_q)
);

// File: tb/cmp_branch_unit_bench.sv
module cmp_branch_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_req = 1'b0;
  logic [31:0] cmp_a = '0;
  logic [31:0] cmp_b = '0;
  logic        br_req = 1'b0;
  logic [3:0]  br_cond = '0;
  logic [9:0]  br_disp = '0;
  logic [31:0] pc = '0;
  logic        br_taken;
  logic [31:0] next_pc;
  logic        bad_cond;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] mdl_a = '0;
  logic [31:0] mdl_b = '0;

  always #5 clk = ~clk;

  cmp_branch_unit u_cmp_branch_unit (
    .clk(clk), .rst_n(rst_n), .cmp_req(cmp_req), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .br_req(br_req), .br_cond(br_cond), .br_disp(br_disp), .pc(pc),
    .br_taken(br_taken), .next_pc(next_pc), .bad_cond(bad_cond)
  );

  // Expected relation, written from R4/R5/R6 with native signed arithmetic
  function automatic bit ref_rel(input logic [3:0] c, input logic [31:0] a,
                                 input logic [31:0] b);
    int signed sa = a;
    int signed sb = b;
    case (c)
      4'd0: return a == b;
      4'd1: return a != b;
      4'd2: return sa < sb;
      4'd3: return sa > sb;
      4'd4: return a < b;
      4'd5: return a > b;
      4'd6: return sa >= sb;
      4'd7: return sa <= sb;
      4'd8: return a >= b;
      4'd9: return a <= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] ref_target(input logic [31:0] p,
                                             input logic [9:0] d);
    int signed off = $signed(d);
    return p + 32'd2 + 32'(off * 2);
  endfunction

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, check, then let the edge update
  task automatic cycle(input bit c, input logic [31:0] a, input logic [31:0] b,
                       input bit br, input logic [3:0] cnd, input logic [9:0] d,
                       input logic [31:0] p, input string req);
    bit ill;
    bit tk;
    logic [31:0] np;
    @(negedge clk);
    cmp_req = c; cmp_a = a; cmp_b = b;
    br_req = br; br_cond = cnd; br_disp = d; pc = p;
    #2;
    ill = br && (cnd > 4'd9);
    tk  = br && !ill && ref_rel(cnd, mdl_a, mdl_b);
    np  = ill ? p : (tk ? ref_target(p, d) : p + 32'd2);
    check(req, {63'd0, br_taken}, {63'd0, tk});
    check(req, {63'd0, bad_cond}, {63'd0, ill});
    check(req, {32'd0, next_pc}, {32'd0, np});
    @(posedge clk);
    if (c) begin mdl_a = a; mdl_b = b; end
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'hFFFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    // R3: latches cleared by reset -> equal holds, signed less does not
    @(negedge clk); rst_n = 1'b1;
    cycle(0, 0, 0, 1, 4'd0, 10'd4, 32'h100, "R3");
    cycle(0, 0, 0, 1, 4'd2, 10'd4, 32'h100, "R3");
    // R10: idle
    cycle(0, 0, 0, 0, 4'd0, 10'd7, 32'h200, "R10");
    // R5/R6: sign-boundary pair, every code
    cycle(1, 32'h8000_0000, 32'h0000_0001, 0, 0, 0, 0, "R1");
    for (int k = 0; k < 10; k++)
      cycle(0, 0, 0, 1, 4'(k), 10'd16, 32'h1000, k < 2 ? "R4" : "R5_R6");
    // R7: extreme displacements and wrap
    cycle(1, 32'd5, 32'd5, 0, 0, 0, 0, "R1");
    cycle(0, 0, 0, 1, 4'd0, 10'h1FF, 32'h4000, "R7");
    cycle(0, 0, 0, 1, 4'd0, 10'h200, 32'h4000, "R7");
    cycle(0, 0, 0, 1, 4'd0, 10'h3FF, 32'h0000_0000, "R7");
    cycle(0, 0, 0, 1, 4'd1, 10'h0F0, 32'hFFFF_FFFE, "R8");
    // R9: every illegal code
    for (int k = 10; k < 16; k++)
      cycle(0, 0, 0, 1, 4'(k), 10'd8, 32'h300, "R9");
    // R11: same-cycle compare and branch uses old values (5,5 -> equal)
    cycle(1, 32'd1, 32'd2, 1, 4'd0, 10'd2, 32'h500, "R11");
    cycle(0, 0, 0, 1, 4'd4, 10'd2, 32'h500, "R11");
    // R2: many branches with no compare in between
    cycle(1, 32'hFFFF_FFF0, 32'h10, 0, 0, 0, 0, "R1");
    for (int k = 0; k < 40; k++)
      cycle(0, $urandom(), $urandom(), 1, 4'($urandom_range(0, 9)),
            10'($urandom()), $urandom() & 32'hFFFF_FFFE, "R2");
    // Random mix
    for (int k = 0; k < 1500; k++) begin
      logic [31:0] a = pick_val();
      logic [31:0] b = ($urandom_range(0, 3) == 0) ? a :
                       (($urandom_range(0, 3) == 0) ? (a ^ 32'h8000_0000) : pick_val());
      cycle($urandom_range(0, 1), a, b, $urandom_range(0, 3) != 0,
            4'($urandom_range(0, 11)), 10'($urandom()),
            $urandom() & 32'hFFFF_FFFE, "R4_R5_R6_R7_R8");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule